// File: doc/BRIEF.md
# Interrupt Pending Priority Tracker

This block keeps the per-vector state that decides which interrupt a processor core takes next. It holds 256 vectors in three bit arrays: a request array, an in-service array and a trigger-mode array. Interrupts arrive on an accept port as a vector and a level/edge flag. The block offers the highest pending vector to the core only when that vector's priority class beats the current processor priority. On an acknowledge handshake the offered vector moves from the request array to the in-service array. An end-of-interrupt strobe retires the top in-service vector and reports it, with its trigger mode, to the upstream controller.

The processor priority comes from the task priority register and the highest in-service vector. The result is re-registered every cycle. The offer is held low in the cycle after any acknowledge, end-of-interrupt or register write, so a priority that has not yet been updated never lets a vector through. A 32-bit word register port gives access to the task priority, the enable register, the processor priority and all 24 array words. Its reads are combinational.

Top module: `irq_prio_tracker`

## Requirements
- R1: After a synchronous reset, all three arrays are zero and the task priority is 0x00. The enable register holds 0x0FF, so software enable is off. The processor priority is 0x00. `irq_pending`, `ack_valid` and `eoi_valid` are low.
- R2: Register addresses are 5 bits wide. Address 0 is the task priority, which keeps write bits 7:0. Address 1 is the enable register, which keeps write bits 9:0. Address 2 is the processor priority and is read-only. Addresses 8+w, 16+w and 24+w read word w (0..7) of the request, in-service and trigger arrays. Writes to the arrays and to address 2 have no effect. Unused bits and unused addresses read as 0.
- R3: Vector v occupies bit v&31 of word v>>5 in each array.
- R4: The unit is enabled only when `hw_en` is 1 and bit 8 of the enable register is 1. While it is disabled, accepts leave the request array unchanged and `irq_pending` stays low.
- R5: An accept sets the vector's request bit. For a level interrupt it sets the trigger bit, and for an edge interrupt it clears it. A level accept whose request bit is already set is discarded, and the trigger bit is left as it was.
- R6: The processor priority register is updated each cycle from the state before that edge. It takes the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector, using 0 when none is in service. Otherwise it takes that vector with the low nibble cleared.
- R7: `irq_pending` is 1 when all of these hold: the unit is enabled, some request bit is set, and (highest request vector & 0xF0) is strictly greater than the processor priority. It is also 0 in the cycle following any acknowledge, `eoi` strobe or register write.
- R8: A clock edge with `irq_pending` and `ack_ready` both high moves the highest request vector into the in-service array. In the next cycle `ack_valid` is high for one cycle with that vector on `ack_vec`. `ack_ready` without `irq_pending` has no effect.
- R9: An `eoi` strobe with some vector in service clears the highest in-service bit and its trigger bit. In the next cycle `eoi_valid` pulses with the vector on `eoi_vec` and its former trigger bit on `eoi_level`. An `eoi` with nothing in service changes nothing and gives no pulse.
- R10: When events coincide in one cycle, they apply in this order. The acknowledge goes first. The end-of-interrupt acts on the in-service array as it was before the edge. The accept goes last, and it sees the request array after the acknowledge has removed its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Hardware enable |
| acc_valid | input | 1 | Accept strobe for an incoming fixed interrupt |
| acc_vec | input | 8 | Incoming vector |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_pending | output | 1 | A deliverable vector is offered |
| ack_ready | input | 1 | Core accepts the offered vector |
| ack_valid | output | 1 | Acknowledged vector is presented |
| ack_vec | output | 8 | Acknowledged vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_valid | output | 1 | End-of-interrupt report pulse |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Trigger mode of the retired vector |

## Verification
The hardest case to reach from the ports is a single cycle where an acknowledge, an end-of-interrupt and an accept of the very vector being acknowledged all land together. Reaching it needs one vector already in service, and a higher-class vector pending, with its offer settled past the hold cycle. The directed sequence builds that state by acknowledging one vector, accepting a higher one and idling one cycle. It then fires all three inputs at once and reads back every array word involved. A long random phase follows, checking against a behavioural model, to mix task priority writes, enable changes and duplicate accepts.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 8;
    localparam int PRIO_W    = 8;
    localparam int WSEL_W    = $clog2(NUM_WORDS);
    localparam int RADDR_W   = 2 + WSEL_W;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        GRP_CTRL = 2'd0,
        GRP_REQ  = 2'd1,
        GRP_SRV  = 2'd2,
        GRP_TRIG = 2'd3
    } reg_grp_e;

    typedef enum logic [WSEL_W-1:0] {
        CTRL_TASK = WSEL_W'(0),
        CTRL_ENAB = WSEL_W'(1),
        CTRL_PROC = WSEL_W'(2)
    } ctrl_sel_e;

    typedef struct packed {
        logic  valid;
        logic  level;
        prio_t vec;
    } eoi_rpt_t;

    function automatic prio_t prio_class(input prio_t v);
        return {v[PRIO_W-1:PRIO_W-4], 4'h0};
    endfunction

    function automatic prio_t calc_ppr(input prio_t task_p, input logic srv_found,
                                       input prio_t srv_vec);
        prio_t sv;
        sv = srv_found ? srv_vec : '0;
        if (task_p[PRIO_W-1:PRIO_W-4] >= sv[PRIO_W-1:PRIO_W-4])
            return task_p;
        return prio_class(sv);
    endfunction

endpackage

// File: rtl/irq_hi_enc.sv
module irq_hi_enc #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int WSEL_W   = $clog2(NUM_WORDS),
    localparam int IDX_W    = BIT_W + WSEL_W
) (
    input  logic [NUM_WORDS*WORD_W-1:0] bits_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            idx_o
);

    logic [NUM_WORDS-1:0]       w_any;
    logic [NUM_WORDS*BIT_W-1:0] w_pos;

    // First level: highest set bit inside each word
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [BIT_W-1:0] pos;
        always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++)
                if (bits_i[w*WORD_W+b]) pos = BIT_W'(b);
        end
        assign w_any[w]                 = |bits_i[w*WORD_W +: WORD_W];
        assign w_pos[w*BIT_W +: BIT_W]  = pos;
    end

    // Second level: highest word that holds any bit
    logic [WSEL_W-1:0] sel;
    always_comb begin
        sel = '0;
        for (int w = 0; w < NUM_WORDS; w++)
            if (w_any[w]) sel = WSEL_W'(w);
    end

    assign found_o = |w_any;
    assign idx_o   = {sel, w_pos[sel*BIT_W +: BIT_W]};

endmodule

// File: rtl/irq_ppr_unit.sv
module irq_ppr_unit
    import irq_prio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prio_t task_i,
    input  logic  srv_found_i,
    input  prio_t srv_vec_i,
    output prio_t ppr_o
);

    always_ff @(posedge clk) begin
        if (rst) ppr_o <= '0;
        else     ppr_o <= calc_ppr(task_i, srv_found_i, srv_vec_i);
    end

endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
    import irq_prio_pkg::*;
#(
    parameter int WORD_W    = irq_prio_pkg::WORD_W,
    parameter int NUM_WORDS = irq_prio_pkg::NUM_WORDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_en,
    input  logic                acc_valid,
    input  logic [7:0]          acc_vec,
    input  logic                acc_level,
    input  logic                reg_we,
    input  logic [4:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq_pending,
    input  logic                ack_ready,
    output logic                ack_valid,
    output logic [7:0]          ack_vec,
    input  logic                eoi,
    output logic                eoi_valid,
    output logic [7:0]          eoi_vec,
    output logic                eoi_level
);

    localparam int NUM_VEC = WORD_W * NUM_WORDS;
    localparam int VEC_W   = $clog2(NUM_VEC);
    localparam int LW_W    = $clog2(NUM_WORDS);
    localparam int ENAB_W  = 10;
    localparam int SW_EN_BIT = 8;

    logic [NUM_VEC-1:0] req_q, srv_q, trig_q;
    logic [NUM_VEC-1:0] req_n, srv_n, trig_n;
    prio_t              task_q;
    logic [ENAB_W-1:0]  enab_q;
    prio_t              ppr_q;
    logic               hold_q;

    logic               req_found, srv_found;
    logic [VEC_W-1:0]   req_hi, srv_hi;
    logic               unit_en, ack_fire, eoi_do, acc_do;
    eoi_rpt_t           eoi_q;

    irq_hi_enc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_req_enc (
        .bits_i(req_q), .found_o(req_found), .idx_o(req_hi)
    );

    irq_hi_enc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_srv_enc (
        .bits_i(srv_q), .found_o(srv_found), .idx_o(srv_hi)
    );

    irq_ppr_unit u_ppr (
        .clk(clk), .rst(rst), .task_i(task_q),
        .srv_found_i(srv_found), .srv_vec_i(prio_t'(srv_hi)), .ppr_o(ppr_q)
    );

    assign unit_en     = hw_en & enab_q[SW_EN_BIT];
    assign irq_pending = unit_en & req_found & ~hold_q &
                         (prio_class(prio_t'(req_hi)) > ppr_q);
    assign ack_fire    = irq_pending & ack_ready;
    assign eoi_do      = eoi & srv_found;
    assign acc_do      = acc_valid & unit_en;

    // Array update: acknowledge, then end-of-interrupt, then accept
    always_comb begin
        req_n  = req_q;
        srv_n  = srv_q;
        trig_n = trig_q;
        if (ack_fire) begin
            srv_n[req_hi] = 1'b1;
            req_n[req_hi] = 1'b0;
        end
        if (eoi_do) begin
            srv_n[srv_hi]  = 1'b0;
            trig_n[srv_hi] = 1'b0;
        end
        if (acc_do && !(req_n[acc_vec] && acc_level)) begin
            req_n[acc_vec]  = 1'b1;
            trig_n[acc_vec] = acc_level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            srv_q     <= '0;
            trig_q    <= '0;
            task_q    <= '0;
            enab_q    <= ENAB_W'(10'h0FF);
            hold_q    <= 1'b0;
            ack_valid <= 1'b0;
            ack_vec   <= '0;
            eoi_q     <= '0;
        end else begin
            req_q     <= req_n;
            srv_q     <= srv_n;
            trig_q    <= trig_n;
            hold_q    <= ack_fire | eoi | reg_we;
            ack_valid <= ack_fire;
            if (ack_fire) ack_vec <= req_hi;
            eoi_q.valid <= eoi_do;
            if (eoi_do) begin
                eoi_q.vec   <= prio_t'(srv_hi);
                eoi_q.level <= trig_q[srv_hi];
            end
            if (reg_we && reg_grp_e'(reg_addr[4:3]) == GRP_CTRL) begin
                if (ctrl_sel_e'(reg_addr[2:0]) == CTRL_TASK) task_q <= reg_wdata[7:0];
                if (ctrl_sel_e'(reg_addr[2:0]) == CTRL_ENAB) enab_q <= reg_wdata[ENAB_W-1:0];
            end
        end
    end

    assign eoi_valid = eoi_q.valid;
    assign eoi_vec   = eoi_q.vec;
    assign eoi_level = eoi_q.level;

    // Register read mux
    logic [LW_W-1:0] rd_w;
    assign rd_w = reg_addr[LW_W-1:0];
    always_comb begin
        reg_rdata = '0;
        unique case (reg_grp_e'(reg_addr[4:3]))
            GRP_CTRL: begin
                if (ctrl_sel_e'(reg_addr[2:0]) == CTRL_TASK) reg_rdata = 32'(task_q);
                if (ctrl_sel_e'(reg_addr[2:0]) == CTRL_ENAB) reg_rdata = 32'(enab_q);
                if (ctrl_sel_e'(reg_addr[2:0]) == CTRL_PROC) reg_rdata = 32'(ppr_q);
            end
            GRP_REQ:  reg_rdata = req_q[rd_w*WORD_W +: WORD_W];
            GRP_SRV:  reg_rdata = srv_q[rd_w*WORD_W +: WORD_W];
            GRP_TRIG: reg_rdata = trig_q[rd_w*WORD_W +: WORD_W];
            default:  reg_rdata = '0;
        endcase
    end

    // R8: presented vector is in service and came from a handshake
    assert_ack_in_service_R8: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> srv_q[ack_vec]);
    assert_ack_cause_R8: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(irq_pending && ack_ready));
    // R9: reported vector is retired and came from a strobe
    assert_eoi_retired_R9: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> !srv_q[eoi_vec]);
    assert_eoi_cause_R9: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> $past(eoi));
    // R4: an accept while disabled leaves a clear request bit clear
    assert_disabled_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !(hw_en && enab_q[SW_EN_BIT]) && !req_q[acc_vec])
        |=> !req_q[$past(acc_vec)]);
    // R6: once settled, processor priority is never below the top in-service class
    assert_ppr_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && srv_found) |-> (ppr_q[7:4] >= srv_hi[7:4]));

endmodule

// File: tb/irq_prio_tracker_bench.sv
module irq_prio_tracker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_vec = '0;
    logic        acc_level = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pending;
    logic        ack_ready = 1'b0;
    logic        ack_valid;
    logic [7:0]  ack_vec;
    logic        eoi = 1'b0;
    logic        eoi_valid;
    logic [7:0]  eoi_vec;
    logic        eoi_level;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_prio_tracker u_irq_prio_tracker (
        .clk(clk), .rst(rst), .hw_en(hw_en),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pending(irq_pending), .ack_ready(ack_ready), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .eoi(eoi), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_level(eoi_level)
    );

    // ---------------- behavioural reference model ----------------
    bit [255:0] m_req, m_srv, m_trig;
    int         m_task, m_enab, m_ppr;
    bit         m_hold, m_ackv, m_eoiv, m_eoil;
    int         m_ackvec, m_eoivec;
    bit         started = 0;

    function automatic int top_bit(bit [255:0] b);
        for (int i = 255; i >= 0; i--) if (b[i]) return i;
        return -1;
    endfunction

    function automatic int ref_ppr(int t, int s);
        int sv = (s < 0) ? 0 : s;
        if ((t >> 4) >= (sv >> 4)) return t;
        return sv & 8'hF0;
    endfunction

    function automatic bit m_pend();
        int h = top_bit(m_req);
        if (!(hw_en && m_enab[8])) return 0;
        if (h < 0 || m_hold) return 0;
        return (h & 8'hF0) > m_ppr;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        int w = a[2:0];
        case (a[4:3])
            2'd0: return (a == 0) ? 32'(m_task) : (a == 1) ? 32'(m_enab) :
                         (a == 2) ? 32'(m_ppr) : 32'h0;
            2'd1: return m_req[w*32 +: 32];
            2'd2: return m_srv[w*32 +: 32];
            default: return m_trig[w*32 +: 32];
        endcase
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_req = '0; m_srv = '0; m_trig = '0;
            m_task = 0; m_enab = 'h0FF; m_ppr = 0; m_hold = 0;
            m_ackv = 0; m_eoiv = 0; m_ackvec = 0; m_eoivec = 0; m_eoil = 0;
        end else begin
            bit fire; int hr, hs, nppr;
            fire = m_pend() && ack_ready;
            hr = top_bit(m_req);
            hs = top_bit(m_srv);
            nppr = ref_ppr(m_task, hs);
            m_ackv = fire;
            if (fire) begin m_ackvec = hr; m_srv[hr] = 1; m_req[hr] = 0; end
            m_eoiv = eoi && (hs >= 0);
            if (m_eoiv) begin
                m_eoivec = hs; m_eoil = m_trig[hs];
                m_srv[hs] = 0; m_trig[hs] = 0;
            end
            if (acc_valid && hw_en && m_enab[8]) begin
                if (!(m_req[acc_vec] && acc_level)) begin
                    m_req[acc_vec] = 1; m_trig[acc_vec] = acc_level;
                end
            end
            m_ppr = nppr;
            m_hold = fire || eoi || reg_we;
            if (reg_we && reg_addr == 0) m_task = reg_wdata[7:0];
            if (reg_we && reg_addr == 1) m_enab = reg_wdata[9:0];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R7 pending vs model", 32'(irq_pending), 32'(m_pend()));
            chk("R8 ack_valid vs model", 32'(ack_valid), 32'(m_ackv));
            if (m_ackv) chk("R8 ack_vec vs model", 32'(ack_vec), 32'(m_ackvec));
            chk("R9 eoi_valid vs model", 32'(eoi_valid), 32'(m_eoiv));
            if (m_eoiv) begin
                chk("R9 eoi_vec vs model", 32'(eoi_vec), 32'(m_eoivec));
                chk("R9 eoi_level vs model", 32'(eoi_level), 32'(m_eoil));
            end
            chk("R2 rdata vs model", reg_rdata, m_read(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(); @(posedge clk); #2; endtask
    task automatic wr(logic [4:0] a, logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d; cyc(); reg_we = 0;
    endtask
    task automatic accept(logic [7:0] v, logic l);
        acc_valid = 1; acc_vec = v; acc_level = l; cyc(); acc_valid = 0;
    endtask
    task automatic do_ack(); ack_ready = 1; cyc(); ack_ready = 0; endtask
    task automatic do_eoi(); eoi = 1; cyc(); eoi = 0; endtask
    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
        reg_addr = a; #1; chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        rd(1, 32'h0FF, "R1 enable reg reset");
        rd(2, 32'h0, "R1 ppr reset");
        rd(16, 32'h0, "R1 isr reset");
        chk("R1 pending reset", 32'(irq_pending), 0);
        // R4 disabled accepts
        accept(8'h30, 0);
        rd(9, 32'h0, "R4 accept with hw_en low dropped");
        hw_en = 1;
        accept(8'h31, 0);
        rd(9, 32'h0, "R4 accept with software enable off dropped");
        // R2 register map
        wr(1, 32'h1FF);
        rd(1, 32'h1FF, "R2 enable reg");
        wr(1, 32'hFFFF_FFFF);
        rd(1, 32'h3FF, "R2 enable reg keeps 10 bits");
        wr(8, 32'h0000_FFFF);
        rd(8, 32'h0, "R2 array write ignored");
        wr(0, 32'hABCD_0012);
        rd(0, 32'h12, "R2 task priority low byte");
        wr(0, 0);
        cyc();
        // R3 / R5 accept
        accept(8'h45, 0);
        cyc();
        rd(10, 32'h20, "R3 vector 0x45 in word 2 bit 5");
        chk("R7 pending after accept", 32'(irq_pending), 1);
        accept(8'h61, 1);
        rd(27, 32'h2, "R5 level accept sets trigger");
        accept(8'h61, 0);
        rd(27, 32'h0, "R5 edge accept clears trigger");
        accept(8'h70, 0);
        accept(8'h70, 1);
        rd(27, 32'h0, "R5 level duplicate dropped");
        rd(11, 32'h10002, "R3 request word 3");
        // R6 / R7 priority gating
        wr(0, 32'h65); cyc();
        rd(2, 32'h65, "R6 ppr from task priority");
        chk("R7 class above ppr offered", 32'(irq_pending), 1);
        wr(0, 32'h75); cyc();
        chk("R7 class below ppr blocked", 32'(irq_pending), 0);
        wr(0, 32'h70); cyc();
        chk("R7 equal class blocked", 32'(irq_pending), 0);
        wr(0, 32'h6F); cyc();
        chk("R7 offered again", 32'(irq_pending), 1);
        wr(0, 32'h6E);
        chk("R7 held in cycle after write", 32'(irq_pending), 0);
        cyc();
        // R8 acknowledge
        do_ack();
        chk("R8 ack_valid", 32'(ack_valid), 1);
        chk("R8 ack_vec", 32'(ack_vec), 32'h70);
        cyc();
        rd(2, 32'h70, "R6 in-service class wins");
        rd(19, 32'h10000, "R3 isr word 3");
        rd(11, 32'h2, "R8 request bit cleared");
        ack_ready = 1; cyc();
        chk("R8 ready without pending ignored", 32'(ack_valid), 0);
        ack_ready = 0;
        wr(0, 0); cyc();
        // R9 end of interrupt
        do_eoi();
        chk("R9 eoi_valid", 32'(eoi_valid), 1);
        chk("R9 eoi_vec", 32'(eoi_vec), 32'h70);
        chk("R9 eoi_level edge", 32'(eoi_level), 0);
        cyc();
        rd(19, 32'h0, "R9 isr cleared");
        rd(2, 32'h0, "R6 ppr back to task");
        do_ack();
        chk("R8 ack_vec 0x61", 32'(ack_vec), 32'h61);
        cyc();
        accept(8'h88, 1); cyc();
        do_ack();
        chk("R8 ack_vec 0x88", 32'(ack_vec), 32'h88);
        cyc();
        rd(28, 32'h100, "R5 trigger for 0x88");
        do_eoi();
        chk("R9 eoi_vec 0x88", 32'(eoi_vec), 32'h88);
        chk("R9 eoi_level level", 32'(eoi_level), 1);
        cyc();
        rd(28, 32'h0, "R9 trigger cleared");
        do_eoi();
        chk("R9 eoi_vec 0x61", 32'(eoi_vec), 32'h61);
        cyc();
        do_eoi();
        chk("R9 empty eoi ignored", 32'(eoi_valid), 0);
        cyc();
        rd(2, 32'h0, "R9 empty eoi leaves ppr");
        // R10 coincident events
        do_ack();
        chk("R8 ack_vec 0x45", 32'(ack_vec), 32'h45);
        cyc();
        accept(8'h92, 0); cyc();
        ack_ready = 1; eoi = 1; acc_valid = 1; acc_vec = 8'h92; acc_level = 1;
        cyc();
        ack_ready = 0; eoi = 0; acc_valid = 0;
        chk("R10 ack takes 0x92", 32'(ack_vec), 32'h92);
        chk("R10 eoi retires 0x45", 32'(eoi_vec), 32'h45);
        rd(12, 32'h40000, "R10 accept after ack re-sets request");
        rd(20, 32'h40000, "R10 isr holds 0x92");
        rd(28, 32'h40000, "R10 trigger level");
        rd(18, 32'h0, "R10 eoi used pre-edge isr");
        do_eoi(); cyc(); cyc();
        chk("R7 pending after retire", 32'(irq_pending), 1);
        wr(1, 32'h0FF); cyc();
        chk("R4 software disable blocks offer", 32'(irq_pending), 0);
        wr(1, 32'h100); hw_en = 0; cyc();
        chk("R4 hardware disable blocks offer", 32'(irq_pending), 0);
        hw_en = 1;
        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            acc_valid = ($urandom_range(0, 3) == 0);
            acc_vec   = 8'($urandom_range(0, 255));
            acc_level = $urandom_range(0, 1);
            ack_ready = $urandom_range(0, 1);
            eoi       = ($urandom_range(0, 5) == 0);
            hw_en     = ($urandom_range(0, 19) != 0);
            reg_we    = 0;
            reg_addr  = 5'($urandom_range(0, 31));
            if (r < 6) begin
                reg_we = 1; reg_addr = 0; reg_wdata = $urandom;
            end else if (r < 8) begin
                reg_we = 1; reg_addr = 1;
                reg_wdata = ($urandom_range(0, 3) == 0) ? 32'h0FF : 32'h1FF;
            end
            cyc();
        end
        acc_valid = 0; ack_ready = 0; eoi = 0; reg_we = 0;
        cyc(); cyc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule